// File: doc/BRIEF.md
# Deadtime Current-Polarity Sense and Duty Correction

This block sits beside one complementary PWM pair driving the upper and lower transistor of a half-bridge. A digital comparator on the bridge output node gives a sense level. Each time a PWM channel rises, the block records that sense level into a status bit for that channel. A rising channel marks the end of the deadtime before its switch turns on.

- The upper channel's capture is called the upper status.
- The lower channel's capture is called the lower status.

Together the two status bits classify the load current into one of four states: large and leaving the pair, large and entering the pair, small near the zero crossing, or an impossible combination.

The classification picks which of two duty values is handed to the PWM generator, to compensate for the voltage error that deadtime adds. The pick, and the duty value that follows it, are taken only when the reload strobe marks a PWM period boundary. A period already under way therefore never sees its duty change.

The sense input is synchronized to the system clock. The PWM levels are assumed to come from the same clock domain. Their rising edges act as sample strobes rather than as clocks.

Top module: `deadtime_polarity_corrector`

## Requirements
- R1: Synchronous active-high reset clears both status bits, sets the polarity code to 00 and the duty output to 0, and sets the selection to value A.
- R2: On a clock edge where `top_pwm_i` is 1 and was 0 at the previous edge, `stat_top_o` takes the level that `sense_i` had SYNC_STAGES clock edges earlier. The new value is visible after that edge.
- R3: On a clock edge where `bot_pwm_i` is 1 and was 0 at the previous edge, `stat_bot_o` takes the level that `sense_i` had SYNC_STAGES clock edges earlier. The new value is visible after that edge.
- R4: A falling edge or a steady level on a PWM input leaves that channel's status bit unchanged, whatever the sense level does.
- R5: `pol_code_o` = {stat_top_o, stat_bot_o}, and it updates in the same cycle as the status bits. The codes mean:
  - 00: large current leaving the pair.
  - 01: small current near the zero crossing.
  - 11: large current entering the pair.
  - 10: invalid.
- R6: When `reload_i` is 1 and the code is 00, the selection becomes A and `duty_o` takes `duty_a_i` after that edge.
- R7: When `reload_i` is 1 and the code is 11, the selection becomes B and `duty_o` takes `duty_b_i` after that edge.
- R8: When `reload_i` is 1 and the code is 01 or 10, the selection is kept. `duty_o` reloads the current value of the kept register.
- R9: While `reload_i` is 0, `duty_o` holds its value even when `duty_a_i` or `duty_b_i` change.
- R10: A reload in the same cycle as a capture strobe uses the code held before that edge. The capture still updates the status bits.
- R11: A sense level applied fewer than SYNC_STAGES edges before a capture edge is not captured. The bit takes the older level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| top_pwm_i | input | 1 | Upper-transistor PWM level |
| bot_pwm_i | input | 1 | Lower-transistor PWM level |
| sense_i | input | 1 | Bridge output comparator level (asynchronous) |
| reload_i | input | 1 | PWM period boundary strobe |
| duty_a_i | input | DUTY_W | Duty value A (current leaving) |
| duty_b_i | input | DUTY_W | Duty value B (current entering) |
| stat_top_o | output | 1 | Upper status bit |
| stat_bot_o | output | 1 | Lower status bit |
| pol_code_o | output | 2 | Current polarity code |
| duty_o | output | DUTY_W | Selected duty value to the PWM generator |

## Verification
The capture strobe from a rising PWM channel and the reload strobe can fall in the same clock cycle. The bench raises a PWM channel and asserts reload at the same negative clock edge. This is done twice: once so that the pre-edge code is 00 and the new code is 10, and once so that the pre-edge code is 11 and the new code is 10. Each time it checks two things: `duty_o` follows the classification held before the edge, and the status bits and code show the fresh capture. A following reload then confirms that the invalid code keeps the selection.

// File: rtl/dtpc_pkg.sv
package dtpc_pkg;

  typedef enum logic [1:0] {
    POL_OUT = 2'b00,
    POL_LOW = 2'b01,
    POL_INV = 2'b10,
    POL_IN  = 2'b11
  } pol_e;

  function automatic pol_e classify(input logic up_bit, input logic lo_bit);
    pol_e r;
    unique case ({up_bit, lo_bit})
      2'b00:   r = POL_OUT;
      2'b11:   r = POL_IN;
      2'b01:   r = POL_LOW;
      default: r = POL_INV;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dtpc_sync.sv
module dtpc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/dtpc_edge.sv
module dtpc_edge (
  input  logic clk,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/dtpc_capture.sv
module dtpc_capture
  import dtpc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sense_s_i,
  input  logic rise_top_i,
  input  logic rise_bot_i,
  output logic dt_top_o,
  output logic dt_bot_o,
  output pol_e pol_o
);
  logic nxt_top, nxt_bot;

  always_comb begin
    nxt_top = rise_top_i ? sense_s_i : dt_top_o;
    nxt_bot = rise_bot_i ? sense_s_i : dt_bot_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dt_top_o <= 1'b0;
      dt_bot_o <= 1'b0;
      pol_o    <= POL_OUT;
    end else begin
      dt_top_o <= nxt_top;
      dt_bot_o <= nxt_bot;
      pol_o    <= classify(nxt_top, nxt_bot);
    end
  end
endmodule

// File: rtl/dtpc_select.sv
module dtpc_select
  import dtpc_pkg::*;
#(
  parameter int DUTY_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload_i,
  input  pol_e              pol_i,
  input  logic [DUTY_W-1:0] duty_a_i,
  input  logic [DUTY_W-1:0] duty_b_i,
  output logic [DUTY_W-1:0] duty_o
);
  logic sel_b_q;
  logic sel_b_nxt;

  always_comb begin
    unique case (pol_i)
      POL_OUT: sel_b_nxt = 1'b0;
      POL_IN:  sel_b_nxt = 1'b1;
      default: sel_b_nxt = sel_b_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_b_q <= 1'b0;
      duty_o  <= '0;
    end else if (reload_i) begin
      sel_b_q <= sel_b_nxt;
      duty_o  <= sel_b_nxt ? duty_b_i : duty_a_i;
    end
  end
endmodule

// File: rtl/deadtime_polarity_corrector.sv
module deadtime_polarity_corrector
  import dtpc_pkg::*;
#(
  parameter int DUTY_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              top_pwm_i,
  input  logic              bot_pwm_i,
  input  logic              sense_i,
  input  logic              reload_i,
  input  logic [DUTY_W-1:0] duty_a_i,
  input  logic [DUTY_W-1:0] duty_b_i,
  output logic              stat_top_o,
  output logic              stat_bot_o,
  output logic [1:0]        pol_code_o,
  output logic [DUTY_W-1:0] duty_o
);
  localparam int NCH = 2;

  logic [NCH-1:0] pwm_lvl;
  logic [NCH-1:0] pwm_rise;
  logic           sense_s;
  pol_e           pol;

  assign pwm_lvl = {bot_pwm_i, top_pwm_i};

  dtpc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .async_i(sense_i),
    .sync_o (sense_s)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_edge
    dtpc_edge u_edge (
      .clk   (clk),
      .lvl_i (pwm_lvl[g]),
      .rise_o(pwm_rise[g])
    );
  end

  dtpc_capture u_cap (
    .clk       (clk),
    .rst       (rst),
    .sense_s_i (sense_s),
    .rise_top_i(pwm_rise[0]),
    .rise_bot_i(pwm_rise[1]),
    .dt_top_o  (stat_top_o),
    .dt_bot_o  (stat_bot_o),
    .pol_o     (pol)
  );

  dtpc_select #(.DUTY_W(DUTY_W)) u_sel (
    .clk     (clk),
    .rst     (rst),
    .reload_i(reload_i),
    .pol_i   (pol),
    .duty_a_i(duty_a_i),
    .duty_b_i(duty_b_i),
    .duty_o  (duty_o)
  );

  assign pol_code_o = pol;
endmodule

// File: rtl/dtpc_checker.sv
module dtpc_checker #(
  parameter int DUTY_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              top_pwm_i,
  input logic              bot_pwm_i,
  input logic              reload_i,
  input logic [DUTY_W-1:0] duty_a_i,
  input logic [DUTY_W-1:0] duty_b_i,
  input logic              stat_top_o,
  input logic              stat_bot_o,
  input logic [1:0]        pol_code_o,
  input logic [DUTY_W-1:0] duty_o
);
  // R4: no rising upper PWM means the upper status holds
  p_top_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(top_pwm_i && !$past(top_pwm_i)) |=> $stable(stat_top_o));

  // R4: no rising lower PWM means the lower status holds
  p_bot_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(bot_pwm_i && !$past(bot_pwm_i)) |=> $stable(stat_bot_o));

  // R5: code always agrees with the status pair
  p_code_match_r5: assert property (@(posedge clk) disable iff (rst)
    pol_code_o == {stat_top_o, stat_bot_o});

  // R6: reload with current leaving loads value A
  p_pick_a_r6: assert property (@(posedge clk) disable iff (rst)
    (reload_i && pol_code_o == 2'b00) |=> duty_o == $past(duty_a_i));

  // R7: reload with current entering loads value B
  p_pick_b_r7: assert property (@(posedge clk) disable iff (rst)
    (reload_i && pol_code_o == 2'b11) |=> duty_o == $past(duty_b_i));

  // R9: duty only moves at a reload
  p_duty_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !reload_i |=> $stable(duty_o));
endmodule

bind deadtime_polarity_corrector dtpc_checker #(.DUTY_W(DUTY_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .top_pwm_i (top_pwm_i),
  .bot_pwm_i (bot_pwm_i),
  .reload_i  (reload_i),
  .duty_a_i  (duty_a_i),
  .duty_b_i  (duty_b_i),
  .stat_top_o(stat_top_o),
  .stat_bot_o(stat_bot_o),
  .pol_code_o(pol_code_o),
  .duty_o    (duty_o)
);

// File: tb/deadtime_polarity_corrector_tb_top.sv
module deadtime_polarity_corrector_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 12;
  localparam int SYNC       = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic top = 1'b0, bot = 1'b0, sense = 1'b0, reload = 1'b0;
  logic [W-1:0] da = '0, db = '0;
  logic stat_top, stat_bot;
  logic [1:0] pol;
  logic [W-1:0] duty;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic e_dt0 = 1'b0, e_dt1 = 1'b0, e_sel = 1'b0;
  logic [W-1:0] e_duty = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  deadtime_polarity_corrector #(.DUTY_W(W), .SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst(rst), .top_pwm_i(top), .bot_pwm_i(bot), .sense_i(sense),
    .reload_i(reload), .duty_a_i(da), .duty_b_i(db),
    .stat_top_o(stat_top), .stat_bot_o(stat_bot), .pol_code_o(pol), .duty_o(duty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic check_status(input string req);
    chk(req, {31'd0, stat_top}, {31'd0, e_dt0});
    chk(req, {31'd0, stat_bot}, {31'd0, e_dt1});
    chk({req, "/R5"}, {30'd0, pol}, {30'd0, e_dt0, e_dt1});
  endtask

  // Capture s on one channel: sense applied SYNC negedges before the rise
  task automatic capture(input bit is_top, input bit s);
    sense = s;
    repeat (SYNC) tick;
    if (is_top) top = 1'b1; else bot = 1'b1;
    tick;
    if (is_top) e_dt0 = s; else e_dt1 = s;
    check_status(is_top ? "R2" : "R3");
    sense = ~s;
    tick;
    if (is_top) top = 1'b0; else bot = 1'b0;
    repeat (SYNC + 1) tick;
    check_status("R4");
  endtask

  task automatic model_reload;
    if ({e_dt0, e_dt1} == 2'b00) e_sel = 1'b0;
    else if ({e_dt0, e_dt1} == 2'b11) e_sel = 1'b1;
    e_duty = e_sel ? db : da;
  endtask

  task automatic do_reload(input string req);
    reload = 1'b1;
    tick;
    reload = 1'b0;
    model_reload();
    chk(req, {20'd0, duty}, {20'd0, e_duty});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    rst = 1'b0;
    tick;
    // R1: reset state
    check_status("R1");
    chk("R1", {20'd0, duty}, 32'd0);

    // R1: selection starts at A; a low-current code keeps it (R8)
    da = 12'h155; db = 12'h2AA;
    capture(1'b0, 1'b1);
    do_reload("R1");

    // Exhaustive sweep: start selection x classification
    for (int st = 0; st < 2; st++) begin
      for (int c = 0; c < 4; c++) begin
        capture(1'b1, st[0]);
        capture(1'b0, st[0]);
        da = W'(c * 37 + st * 300 + 5);
        db = ~da;
        do_reload(st == 1 ? "R7" : "R6");
        capture(1'b1, c[1]);
        capture(1'b0, c[0]);
        da = da + W'(11);
        db = db - W'(7);
        do_reload(c == 0 ? "R6" : (c == 3 ? "R7" : "R8"));
        // R9: values move, no reload
        da = da + W'(1);
        db = db + W'(3);
        repeat (3) tick;
        chk("R9", {20'd0, duty}, {20'd0, e_duty});
      end
    end

    // R11: sense applied one edge before the rise is not seen
    capture(1'b1, 1'b0);
    sense = 1'b0;
    repeat (4) tick;
    sense = 1'b1;
    tick;
    top = 1'b1;
    tick;
    chk("R11", {31'd0, stat_top}, 32'd0);
    top = 1'b0;
    repeat (3) tick;

    // R10: capture and reload together, old code 00 -> A, new code 10
    capture(1'b1, 1'b0);
    capture(1'b0, 1'b0);
    do_reload("R6");
    da = 12'h321; db = 12'h654;
    sense = 1'b1;
    repeat (SYNC) tick;
    top = 1'b1;
    reload = 1'b1;
    tick;
    reload = 1'b0;
    model_reload();
    e_dt0 = 1'b1;
    chk("R10", {20'd0, duty}, {20'd0, 12'h321});
    check_status("R10");
    top = 1'b0;
    repeat (3) tick;

    // R10: old code 11 -> B while lower capture makes code 10
    capture(1'b0, 1'b1);
    do_reload("R7");
    da = 12'h0F0; db = 12'h70F;
    sense = 1'b0;
    repeat (SYNC) tick;
    bot = 1'b1;
    reload = 1'b1;
    tick;
    reload = 1'b0;
    model_reload();
    e_dt1 = 1'b0;
    chk("R10", {20'd0, duty}, {20'd0, 12'h70F});
    check_status("R10");
    bot = 1'b0;
    repeat (3) tick;
    // R8: invalid code keeps B
    db = 12'h111;
    do_reload("R8");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule